// File: doc/BRIEF.md
# Security-Banked System Handler Priority Registers

This block keeps the 8-bit priority values of the configurable system exceptions, handler numbers 4 to 15, and shows them on three 32-bit words of a peripheral register port starting at byte offset 0xD18. Each request carries a security attribute. For handlers whose priority is kept once per security state, the attribute picks the copy that is read or written. For handlers with a single copy, the attribute, together with a control input that opens the bus-fault priority to non-secure software, decides whether the lane is reachable or reads as zero and ignores writes.

Each byte lane of an access is decoded on its own: lane i of the word at offset o belongs to handler (o − 0xD14) + i. Both the shared copies and the secure copies are exported as flat vectors to the exception prioritisation logic. A one-cycle update strobe tells that logic to recompute its pending state after every write to the window.

Top module: `handler_prio_bank`

## Requirements
- R1: Lane i of the word at byte offset 0xD18, 0xD1C or 0xD20 addresses handler (offset − 0xD14) + i. The shared copy of handler h is exported on prioMainOut[(h−4)*8 +: 8] and the secure copy on prioSecOut[(h−4)*8 +: 8].
- R2: Handlers 4, 6, 11, 14 and 15 have two copies. A secure access reads and writes the secure copy, and a non-secure access reads and writes the shared copy. prioSecOut is zero in every slot of a handler that has no secure copy.
- R3: Handler 5 has one copy. Secure accesses always reach it. Non-secure accesses reach it only while bfNsEnable is 1, and otherwise read 0 and leave it unchanged.
- R4: Handler 7 has one copy. Secure accesses reach it, and non-secure accesses read 0 and leave it unchanged.
- R5: Handler 12 has one copy, and it is read and written the same way from either security state.
- R6: Handlers 8, 9, 10 and 13 always read 0 and ignore writes.
- R7: Lanes are independent. A lane whose reqByteEn bit is 0 is not written and reads as 0. A lane that reads as zero and ignores writes does not affect the other lanes of the same access.
- R8: updStrobe is high for exactly the cycle after each write request whose word address is inside the window, whatever its byte enables. It stays low after reads and after writes outside the window.
- R9: Every read request is answered by rspValid with rspRdata on the next cycle. A read outside the window returns 0, and a write outside the window, or a cycle with no request, changes no priority.
- R10: After reset all priorities are 0, and rspValid and updStrobe are low.
- R11: A non-secure access never changes any secure copy, whatever byte enables it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 32 | Byte address; bits [1:0] are ignored |
| reqWdata | input | 32 | Write data, lane i in bits [8i+7:8i] |
| reqByteEn | input | 4 | Lane enables |
| reqSecure | input | 1 | 1 when the access is secure |
| bfNsEnable | input | 1 | Opens the bus-fault priority to non-secure accesses |
| rspValid | output | 1 | Read data valid |
| rspRdata | output | 32 | Read data |
| updStrobe | output | 1 | One-cycle pulse after a write to the window |
| prioMainOut | output | 96 | Shared or non-secure priority of handlers 4 to 15 |
| prioSecOut | output | 96 | Secure priority of the two-copy handlers, zero elsewhere |

## Verification
A lane routed to the wrong copy shows up on prioMainOut or prioSecOut in the cycle after the write. It also shows up as a mismatch on the next read of that word from either security state. For this reason every write is followed by a comparison of both export vectors against a reference model, and the reads go through both attributes and both settings of the bus-fault control. A missed or doubled update strobe is visible one cycle after the request. A lane that should read as zero and leaks data shows up in the response of the next read of that word.

// File: rtl/hprio_pkg.sv
package hprio_pkg;
  localparam int PRIO_W    = 8;
  localparam int LANES     = 4;
  localparam int DATA_W    = LANES * PRIO_W;
  localparam int HDL_FIRST = 4;
  localparam int HDL_COUNT = 12;
  localparam int NUM_WORDS = HDL_COUNT / LANES;
  localparam int VEC_W     = HDL_COUNT * PRIO_W;

  localparam int HDL_MEMMGMT  = 4;
  localparam int HDL_BUSFLT   = 5;
  localparam int HDL_USAGE    = 6;
  localparam int HDL_SECFLT   = 7;
  localparam int HDL_SVC      = 11;
  localparam int HDL_DEBUGMON = 12;
  localparam int HDL_PENDSV   = 14;
  localparam int HDL_SYSTICK  = 15;

  typedef enum logic [1:0] {BANK_NONE, BANK_MAIN, BANK_SEC} bank_e;

  typedef struct packed {
    logic [HDL_COUNT-1:0] wrMain;
    logic [HDL_COUNT-1:0] wrSec;
    logic [HDL_COUNT-1:0] rdMain;
    logic [HDL_COUNT-1:0] rdSec;
    logic                 rdEn;
    logic                 wrHit;
  } prio_ctrl_t;

  // Which copy a lane reaches, or none (read zero, write ignored).
  function automatic bank_e laneBank(input int hdl, input logic secure, input logic bfNsEn);
    bank_e b;
    b = BANK_NONE;
    case (hdl)
      HDL_MEMMGMT, HDL_USAGE, HDL_SVC, HDL_PENDSV, HDL_SYSTICK:
        b = secure ? BANK_SEC : BANK_MAIN;
      HDL_BUSFLT:   b = (secure || bfNsEn) ? BANK_MAIN : BANK_NONE;
      HDL_SECFLT:   b = secure ? BANK_MAIN : BANK_NONE;
      HDL_DEBUGMON: b = BANK_MAIN;
      default:      b = BANK_NONE;
    endcase
    return b;
  endfunction

  function automatic logic hasSecCopy(input int hdl);
    return laneBank(hdl, 1'b1, 1'b0) == BANK_SEC;
  endfunction
endpackage

// File: rtl/hprio_ctrl.sv
module hprio_ctrl
  import hprio_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0D18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic              reqSecure,
  input  logic              bfNsEnable,
  output prio_ctrl_t        ctrl,
  output logic              rspValid,
  output logic              updStrobe
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] BASE_WORD = BASE_ADDR[ADDR_W-1:2];

  logic [WORD_W-1:0] wordOfs;
  logic              inRange;
  logic              unusedLowAddr;

  assign wordOfs       = reqAddr[ADDR_W-1:2] - BASE_WORD;
  assign inRange       = wordOfs < WORD_W'(NUM_WORDS);
  assign unusedLowAddr = ^reqAddr[1:0];

  always_comb begin
    ctrl       = '0;
    ctrl.rdEn  = reqValid & ~reqWrite;
    ctrl.wrHit = reqValid & reqWrite & inRange;
    for (int k = 0; k < HDL_COUNT; k++) begin
      if (reqValid && inRange && (wordOfs == WORD_W'(k / LANES)) && reqByteEn[k % LANES]) begin
        case (laneBank(HDL_FIRST + k, reqSecure, bfNsEnable))
          BANK_MAIN: begin
            if (reqWrite) ctrl.wrMain[k] = 1'b1;
            else          ctrl.rdMain[k] = 1'b1;
          end
          BANK_SEC: begin
            if (reqWrite) ctrl.wrSec[k] = 1'b1;
            else          ctrl.rdSec[k] = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      updStrobe <= 1'b0;
    end else begin
      rspValid  <= ctrl.rdEn;
      updStrobe <= ctrl.wrHit;
    end
  end
endmodule

// File: rtl/hprio_regs.sv
module hprio_regs
  import hprio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  prio_ctrl_t        ctrl,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [VEC_W-1:0]  prioMainOut,
  output logic [VEC_W-1:0]  prioSecOut
);
  logic [DATA_W-1:0] rdataD;
  logic              unusedHit;

  assign unusedHit = ctrl.wrHit;

  for (genvar k = 0; k < HDL_COUNT; k++) begin : gSlot
    localparam int LANE = k % LANES;
    logic [PRIO_W-1:0] mainReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               mainReg <= '0;
      else if (ctrl.wrMain[k]) mainReg <= reqWdata[LANE*PRIO_W +: PRIO_W];
    end
    assign prioMainOut[k*PRIO_W +: PRIO_W] = mainReg;

    if (hasSecCopy(HDL_FIRST + k)) begin : gBanked
      logic [PRIO_W-1:0] secReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              secReg <= '0;
        else if (ctrl.wrSec[k]) secReg <= reqWdata[LANE*PRIO_W +: PRIO_W];
      end
      assign prioSecOut[k*PRIO_W +: PRIO_W] = secReg;
    end else begin : gShared
      logic unusedSecCtl;
      assign unusedSecCtl = ctrl.wrSec[k] | ctrl.rdSec[k];
      assign prioSecOut[k*PRIO_W +: PRIO_W] = '0;
    end
  end

  always_comb begin
    rdataD = '0;
    for (int k = 0; k < HDL_COUNT; k++) begin
      if (ctrl.rdMain[k])
        rdataD[(k % LANES)*PRIO_W +: PRIO_W] = rdataD[(k % LANES)*PRIO_W +: PRIO_W]
                                               | prioMainOut[k*PRIO_W +: PRIO_W];
      if (ctrl.rdSec[k])
        rdataD[(k % LANES)*PRIO_W +: PRIO_W] = rdataD[(k % LANES)*PRIO_W +: PRIO_W]
                                               | prioSecOut[k*PRIO_W +: PRIO_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rspRdata <= '0;
    else if (ctrl.rdEn) rspRdata <= rdataD;
    else                rspRdata <= '0;
  end
endmodule

// File: rtl/handler_prio_bank.sv
module handler_prio_bank
  import hprio_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0D18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic              reqSecure,
  input  logic              bfNsEnable,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              updStrobe,
  output logic [VEC_W-1:0]  prioMainOut,
  output logic [VEC_W-1:0]  prioSecOut
);
  prio_ctrl_t ctrl;

  hprio_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqByteEn  (reqByteEn),
    .reqSecure  (reqSecure),
    .bfNsEnable (bfNsEnable),
    .ctrl       (ctrl),
    .rspValid   (rspValid),
    .updStrobe  (updStrobe)
  );

  hprio_regs uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqWdata    (reqWdata),
    .rspRdata    (rspRdata),
    .prioMainOut (prioMainOut),
    .prioSecOut  (prioSecOut)
  );
endmodule

// File: rtl/hprio_checker.sv
module hprio_checker
  import hprio_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h0D18
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-3:0] reqWordAddr,
  input logic              reqSecure,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspRdata,
  input logic              updStrobe,
  input logic [VEC_W-1:0]  prioMainOut,
  input logic [VEC_W-1:0]  prioSecOut
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] BASE_WORD = BASE_ADDR[ADDR_W-1:2];

  logic [WORD_W-1:0] wordOfs;
  logic              inRange;
  logic              wrIn;

  assign wordOfs = reqWordAddr - BASE_WORD;
  assign inRange = wordOfs < WORD_W'(NUM_WORDS);
  assign wrIn    = reqValid & reqWrite & inRange;

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqWrite |=> rspValid); // R9
  AST_ANSWER_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && !reqWrite)); // R9
  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    wrIn |=> updStrobe); // R8
  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> $past(wrIn)); // R8
  AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrIn |=> $stable(prioMainOut) && $stable(prioSecOut)); // R9
  AST_NONSECURE_SPARES_SEC: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqSecure |=> $stable(prioSecOut)); // R11
  AST_RESERVED_READ_ZERO_A: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(wordOfs == WORD_W'(1)) |-> rspRdata[23:0] == 24'h0); // R6
  AST_RESERVED_READ_ZERO_B: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(wordOfs == WORD_W'(2)) |-> rspRdata[15:8] == 8'h0); // R6
  AST_SECFAULT_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(!reqSecure && wordOfs == WORD_W'(0)) |-> rspRdata[31:24] == 8'h0); // R4
  AST_RESERVED_NEVER_SET: assert property (@(posedge clk) disable iff (!rstN)
    prioMainOut[(8-HDL_FIRST)*PRIO_W +: 3*PRIO_W] == '0 &&
    prioMainOut[(13-HDL_FIRST)*PRIO_W +: PRIO_W] == '0); // R6
endmodule

bind handler_prio_bank hprio_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqWordAddr (reqAddr[ADDR_W-1:2]),
  .reqSecure   (reqSecure),
  .rspValid    (rspValid),
  .rspRdata    (rspRdata),
  .updStrobe   (updStrobe),
  .prioMainOut (prioMainOut),
  .prioSecOut  (prioSecOut)
);

// File: tb/handler_prio_bank_test.sv
module handler_prio_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSecure = 1'b0, bfNsEnable = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [3:0]  reqByteEn = '0;
  logic        rspValid, updStrobe;
  logic [31:0] rspRdata;
  logic [95:0] prioMainOut, prioSecOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mMain [16];
  logic [7:0] mSec  [16];
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2 clk = ~clk;

  handler_prio_bank uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn), .reqSecure(reqSecure), .bfNsEnable(bfNsEnable),
    .rspValid(rspValid), .rspRdata(rspRdata), .updStrobe(updStrobe),
    .prioMainOut(prioMainOut), .prioSecOut(prioSecOut)
  );

  task automatic checkVal(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // 0: no copy reachable, 1: shared copy, 2: secure copy
  function automatic int bankOf(int h, bit sec, bit bf);
    case (h)
      4, 6, 11, 14, 15: return sec ? 2 : 1;
      5:  return (!sec && !bf) ? 0 : 1;
      7:  return sec ? 1 : 0;
      12: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int wordOf(logic [31:0] addr);
    int w;
    w = int'(addr[31:2]) - int'(32'hD18 >> 2);
    return (w < 0 || w > 2) ? -1 : w;
  endfunction

  function automatic logic [95:0] flatMain();
    logic [95:0] v;
    for (int k = 0; k < 12; k++) v[k*8 +: 8] = mMain[k+4];
    return v;
  endfunction

  function automatic logic [95:0] flatSec();
    logic [95:0] v;
    for (int k = 0; k < 12; k++) v[k*8 +: 8] = mSec[k+4];
    return v;
  endfunction

  task automatic issue(bit wr, logic [31:0] addr, logic [31:0] data, logic [3:0] be, bit sec, string tag);
    int w;
    logic [31:0] exp;
    w = wordOf(addr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    reqByteEn = be; reqSecure = sec;
    exp = '0;
    if (w >= 0) begin
      for (int i = 0; i < 4; i++) begin
        if (be[i]) begin
          int h, b;
          h = 4 + 4*w + i;
          b = bankOf(h, sec, bfNsEnable);
          if (wr) begin
            if (b == 1) mMain[h] = data[i*8 +: 8];
            if (b == 2) mSec[h]  = data[i*8 +: 8];
          end else begin
            if (b == 1) exp[i*8 +: 8] = mMain[h];
            if (b == 2) exp[i*8 +: 8] = mSec[h];
          end
        end
      end
    end
    if (!wr) begin
      expQ.push_back(exp);
      tagQ.push_back(tag);
    end
    @(negedge clk);
    reqValid = 1'b0;
    checkVal({"R8 strobe ", tag}, {95'b0, updStrobe}, {95'b0, (wr && w >= 0)});
    if (wr) begin
      checkVal({"shared copies ", tag}, prioMainOut, flatMain());
      checkVal({"R2 R11 secure copies ", tag}, prioSecOut, flatSec());
    end
  endtask

  // Monitor: each response is compared with the oldest expected read.
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        checkVal("R9 response with no read", 96'h1, 96'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal({"read ", t}, {64'b0, rspRdata}, {64'b0, e});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int h = 0; h < 16; h++) begin mMain[h] = '0; mSec[h] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R10 shared after reset", prioMainOut, '0);
    checkVal("R10 secure after reset", prioSecOut, '0);
    checkVal("R10 flags after reset", {94'b0, rspValid, updStrobe}, '0);

    issue(0, 32'hD18, 0, 4'hF, 1, "R10 R1 word0 secure zero");
    issue(0, 32'hD20, 0, 4'hF, 0, "R10 word2 nonsecure zero");

    // R1 R2 R4 secure fill of word 0
    issue(1, 32'hD18, 32'h44332211, 4'hF, 1, "R1 R2 secure word0");
    bfNsEnable = 1'b0;
    issue(1, 32'hD18, 32'hAABBCCDD, 4'hF, 0, "R3 R4 R11 nonsecure word0 bf=0");
    issue(0, 32'hD18, 0, 4'hF, 0, "R3 R4 nonsecure read word0");
    issue(0, 32'hD18, 0, 4'hF, 1, "R2 R4 secure read word0");
    bfNsEnable = 1'b1;
    issue(1, 32'hD18, 32'h00009900, 4'h2, 0, "R3 bf=1 nonsecure byte");
    issue(0, 32'hD18, 0, 4'hF, 0, "R3 bf=1 nonsecure read");
    issue(0, 32'hD18, 0, 4'hF, 1, "R3 secure sees bf write");

    // R6 R2 word1, R5 R6 word2
    issue(1, 32'hD1C, 32'h5A5A5A5A, 4'hF, 1, "R6 R2 secure word1");
    issue(1, 32'hD1C, 32'h3C3C3C3C, 4'hF, 0, "R6 R2 nonsecure word1");
    issue(0, 32'hD1C, 0, 4'hF, 0, "R6 read word1 nonsecure");
    issue(0, 32'hD1C, 0, 4'hF, 1, "R6 read word1 secure");
    issue(1, 32'hD20, 32'h87654321, 4'hF, 0, "R5 R6 nonsecure word2");
    issue(0, 32'hD20, 0, 4'hF, 1, "R5 secure reads shared debug");
    issue(1, 32'hD20, 32'hF0E0D0C0, 4'h3, 1, "R5 R7 secure halfword word2");
    issue(0, 32'hD20, 0, 4'hF, 0, "R5 R7 nonsecure read word2");
    issue(0, 32'hD20, 0, 4'hF, 1, "R7 secure read word2");

    // R7 lane enables
    issue(1, 32'hD18, 32'h11223344, 4'hC, 0, "R7 upper halfword nonsecure");
    issue(0, 32'hD18, 0, 4'h5, 1, "R7 sparse read secure");
    issue(0, 32'hD1C, 0, 4'h0, 1, "R7 read no lanes");
    issue(1, 32'hD1C, 32'hFFFFFFFF, 4'h0, 1, "R7 R8 write no lanes");

    // R9 outside the window, R11 nonsecure sweep
    issue(1, 32'hD14, 32'hFFFFFFFF, 4'hF, 1, "R9 write below window");
    issue(1, 32'hD24, 32'hFFFFFFFF, 4'hF, 1, "R9 write above window");
    issue(0, 32'hD24, 0, 4'hF, 1, "R9 read above window");
    issue(1, 32'hD20, 32'h12345678, 4'hF, 0, "R11 nonsecure word2");

    for (int n = 0; n < 120; n++) begin
      logic [31:0] a, d;
      a = 32'hD14 + 4 * ($urandom % 5);
      d = $urandom;
      bfNsEnable = $urandom % 2;
      issue($urandom % 2, a, d, 4'($urandom), $urandom % 2, "R1 R7 random mix");
    end

    repeat (3) @(negedge clk);
    checkVal("R9 all reads answered", 96'(expQ.size()), '0);
    finishRun();
  end
endmodule